// File: doc/BRIEF.md
# Two-Pin General-Purpose I/O Control Register

This block is one 32-bit control and status word that runs two general-purpose pins. Software selects the word by its word offset on a simple read/write port. Through that word it sets, for each pin, whether the pin drives or floats, whether its polarity is flipped, the level to drive, and whether a change on the pin raises an event. The pad cells sit outside the block. For each pin the block hands them a drive value and an output-enable, and it takes back the raw input level.

Each raw input passes through a two-flop synchronizer. The synchronized level is what software reads in the pin's data field, so a read returns the live pin and not the stored drive value. The block compares the synchronized level with its value one clock earlier. When the level has changed and that pin's change-interrupt enable is set, the block emits a one-clock event pulse on that pin's own output. Mask and status registers downstream collect these pulses.

Top module: `gpio_pair_ctl`

## Requirements
- R1: After reset the word reads 0x0000_0000, both output-enables are low and both event outputs are low.
- R2: Pin index 0 uses bits 23 (change-interrupt enable), 21 (invert), 20 (output enable) and 16 (data). Pin index 1 uses bits 31, 29, 28 and 24 for the same controls. A write to the word stores the enable, invert and output-enable bits, and they read back at those positions.
- R3: Bits 30, 27..25, 22, 19..17 and 15..0 always read 0, whatever value was written to them.
- R4: `pin_oe[i]` equals the stored output-enable bit of pin i, from the clock edge that captures the write onward.
- R5: `pin_out[i]` equals the stored data bit of pin i XOR its invert bit.
- R6: The data bit of pin i reads as the input level of `pin_in[i]` sampled two rising edges earlier, XOR the invert bit. It never returns the written data.
- R7: While pin i's interrupt enable is set, each change of `pin_in[i]` in either direction makes `pin_evt[i]` high for exactly one clock, starting at the third rising edge after the change.
- R8: A change that is detected while pin i's interrupt enable is clear gives no pulse, and it does not cause a pulse when the enable is set later.
- R9: While `reg_sel` differs from `REG_WORD`, `reg_rdata` is 0 and a write changes no stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | ADDR_W | Word offset of the access |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_sel) |
| pin_in | input | NUM_PINS | Raw pin input levels from the pads |
| pin_out | output | NUM_PINS | Drive value per pin |
| pin_oe | output | NUM_PINS | Drive enable per pin; low means high impedance |
| pin_evt | output | NUM_PINS | One-clock level-change event per pin |

## Verification
Assertions check four things on every cycle: reserved bits read zero, an unselected offset reads zero and leaves the stored state untouched, output-enables follow the written bits one edge later, and no event pulse appears unless the enable was set on the clock before. Some behaviour needs a sequence of cycles to observe: the two-edge read latency of the live input, the polarity flip on both the drive and read paths, the exact cycle of the event pulse on rising and falling inputs, and the fact that a change seen while disabled is forgotten. The bench's cycle model and its directed scenarios cover these.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

    localparam int REG_W      = 32;
    localparam int NUM_PINS   = 2;
    localparam int PIN_BASE   = 16;
    localparam int PIN_STRIDE = 8;
    localparam int OFS_DAT    = 0;
    localparam int OFS_OE     = 4;
    localparam int OFS_INV    = 5;
    localparam int OFS_IEN    = 7;

    typedef struct packed {
        logic ien;
        logic inv;
        logic oe;
        logic dat;
    } pin_cfg_t;

    function automatic int pin_base(input int idx);
        return PIN_BASE + idx * PIN_STRIDE;
    endfunction

    function automatic logic [REG_W-1:0] live_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            m[pin_base(i) + OFS_DAT] = 1'b1;
            m[pin_base(i) + OFS_OE]  = 1'b1;
            m[pin_base(i) + OFS_INV] = 1'b1;
            m[pin_base(i) + OFS_IEN] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic ien_i,
    output logic lvl_o,
    output logic evt_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
        logic              evt;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_i};
        st_d.prev  = st_q.chain[STAGES-1];
        st_d.evt   = (st_q.chain[STAGES-1] ^ st_q.prev) & ien_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.chain[STAGES-1];
    assign evt_o = st_q.evt;

    AST_EVT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(ien_i)); // R8

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pair_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [REG_W-1:0]              wdata_i,
    output pin_cfg_t [NUM_PINS-1:0]       cfg_o
);

    pin_cfg_t [NUM_PINS-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                cfg_d[i].dat = wdata_i[pin_base(i) + OFS_DAT];
                cfg_d[i].oe  = wdata_i[pin_base(i) + OFS_OE];
                cfg_d[i].inv = wdata_i[pin_base(i) + OFS_INV];
                cfg_d[i].ien = wdata_i[pin_base(i) + OFS_IEN];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/gpio_pair_ctl.sv
module gpio_pair_ctl
    import gpio_pair_pkg::*;
#(
    parameter int               ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_WORD = 6'h3F,
    parameter int               STAGES   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_sel,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NUM_PINS-1:0]  pin_in,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe,
    output logic [NUM_PINS-1:0]  pin_evt
);

    localparam logic [REG_W-1:0] LIVE = live_mask();

    logic                    hit;
    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic [NUM_PINS-1:0]     lvl;
    logic [NUM_PINS-1:0]     ien_vec;

    assign hit = (reg_sel == REG_WORD);

    gpio_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr & hit),
        .wdata_i (reg_wdata),
        .cfg_o   (cfg)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign ien_vec[g] = cfg[g].ien;
        assign pin_out[g] = cfg[g].dat ^ cfg[g].inv;
        assign pin_oe[g]  = cfg[g].oe;

        gpio_in_sync #(.STAGES(STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pin_in[g]),
            .ien_i (ien_vec[g]),
            .lvl_o (lvl[g]),
            .evt_o (pin_evt[g])
        );

        AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && hit) |=> pin_oe[g] == $past(reg_wdata[pin_base(g) + OFS_OE])); // R4
    end

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                reg_rdata[pin_base(i) + OFS_DAT] = lvl[i] ^ cfg[i].inv;
                reg_rdata[pin_base(i) + OFS_OE]  = cfg[i].oe;
                reg_rdata[pin_base(i) + OFS_INV] = cfg[i].inv;
                reg_rdata[pin_base(i) + OFS_IEN] = cfg[i].ien;
            end
        end
    end

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~LIVE) == '0); // R3

    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> reg_rdata == '0); // R9

endmodule

// File: tb/gpio_pair_ctl_tb_top.sv
`timescale 1ns/1ps
module gpio_pair_ctl_tb_top;

    localparam logic [5:0] WORD = 6'h3F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_sel = WORD;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pin_in = '0;
    logic [1:0]  pin_out, pin_oe, pin_evt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_pair_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_evt(pin_evt)
    );

    // behavioural reference model
    logic [1:0] m_ien = '0, m_inv = '0, m_oe = '0, m_dat = '0, m_evt = '0;
    logic [1:0] hist[$] = '{2'b00, 2'b00, 2'b00};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_word(input logic [5:0] sel);
        logic [31:0] w;
        w = '0;
        if (sel == WORD) begin
            for (int i = 0; i < 2; i++) begin
                w[16 + 8*i] = hist[1][i] ^ m_inv[i];
                w[20 + 8*i] = m_oe[i];
                w[21 + 8*i] = m_inv[i];
                w[23 + 8*i] = m_ien[i];
            end
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ien = '0; m_inv = '0; m_oe = '0; m_dat = '0; m_evt = '0;
            hist = '{2'b00, 2'b00, 2'b00};
        end else begin
            m_evt = (hist[1] ^ hist[2]) & m_ien;
            hist.push_front(pin_in);
            void'(hist.pop_back());
            if (reg_wr && reg_sel == WORD) begin
                for (int i = 0; i < 2; i++) begin
                    m_dat[i] = reg_wdata[16 + 8*i];
                    m_oe[i]  = reg_wdata[20 + 8*i];
                    m_inv[i] = reg_wdata[21 + 8*i];
                    m_ien[i] = reg_wdata[23 + 8*i];
                end
            end
        end
        #1;
        chk("R2 R3 R6 R9", "model rdata", reg_rdata, model_word(reg_sel));
        chk("R4", "model oe", {30'd0, pin_oe}, {30'd0, m_oe});
        chk("R5", "model out", {30'd0, pin_out}, {30'd0, m_dat ^ m_inv});
        chk("R7 R8", "model evt", {30'd0, pin_evt}, {30'd0, m_evt});
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = WORD;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset rdata", reg_rdata, 32'h0);
        chk("R1", "reset oe", {30'd0, pin_oe}, 32'h0);
        chk("R1", "reset evt", {30'd0, pin_evt}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3: every bit set; data reads input 0 inverted
        wr(WORD, 32'hFFFF_FFFF);
        #1;
        chk("R2", "all ones readback", reg_rdata, 32'hB1B1_0000);
        chk("R3", "reserved bits", reg_rdata & 32'h4E4E_FFFF, 32'h0);
        chk("R4", "oe set", {30'd0, pin_oe}, 32'h3);
        chk("R5", "out inverted", {30'd0, pin_out}, 32'h0);

        // R6: data written 1, input 0, no invert -> reads 0
        wr(WORD, 32'h0101_0000);
        #1;
        chk("R6", "data reads input", reg_rdata, 32'h0);
        chk("R5", "out plain", {30'd0, pin_out}, 32'h3);
        chk("R4", "oe clear", {30'd0, pin_oe}, 32'h0);

        // R9: other offset
        wr(6'h3E, 32'hFFFF_FFFF);
        #1;
        chk("R9", "word untouched", reg_rdata, 32'h0);
        chk("R9", "oe untouched", {30'd0, pin_oe}, 32'h0);
        reg_sel = 6'h3E;
        #1;
        chk("R9", "miss reads zero", reg_rdata, 32'h0);
        reg_sel = WORD;

        // R7: rising and falling with enable on pin 0
        wr(WORD, 32'h0080_0000);
        pin_in[0] = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R6", "input seen after two edges", reg_rdata, 32'h0081_0000);
        chk("R7", "no pulse yet", {30'd0, pin_evt}, 32'h0);
        @(posedge clk); #1;
        chk("R7", "rise pulse", {30'd0, pin_evt}, 32'h1);
        @(posedge clk); #1;
        chk("R7", "pulse one clock", {30'd0, pin_evt}, 32'h0);
        @(negedge clk);
        pin_in[0] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R7", "fall pulse", {30'd0, pin_evt}, 32'h1);

        // R8: change while disabled, then enable
        wr(WORD, 32'h0);
        pin_in[1] = 1'b1;
        repeat (6) @(negedge clk);
        wr(WORD, 32'h8000_0000);
        repeat (4) begin
            @(posedge clk); #1;
            chk("R8", "no late pulse", {30'd0, pin_evt}, 32'h0);
        end

        // random phase, compared by the model every clock
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            seed = seed * 32'd1103515245 + 32'd12345;
            if (seed[20:18] == 3'd0) pin_in = seed[25:24];
            if (seed[28:26] == 3'd0) begin
                reg_wr = 1'b1;
                reg_sel = seed[29] ? WORD : seed[5:0];
                reg_wdata = {seed[15:0], seed[31:16]} ^ {seed[7:0], 24'h0};
            end else begin
                reg_wr = 1'b0;
                reg_sel = seed[30] ? WORD : seed[11:6];
            end
        end
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule